// File: doc/BRIEF.md
# Pin Attribute Configuration Bank

This block holds the electrical and function-select settings for a group of pads. Each pad owns one 16-bit attribute word that sets its pull resistor, edge rate, passive input filter, open-drain mode, drive strength and function selector, plus a lock flag. The fields of every word are driven out continuously as per-pad control vectors, straight from the storage flops, so the pad ring sees stable registered levels.

Software reaches the bank through a simple valid/write strobe bus with word addresses. Addresses 0 to NUM_PINS-1 select one pad's word for read or write. That lets a driver change one field, such as the function selector, by read-modify-write. Two more write-only addresses fan a single attribute word into many pads at once: the upper half of the bus word is a pad mask and the lower half is the attribute data. A pad whose lock flag is set ignores every later write until reset.

Top module: `pin_cfg_bank`

## Requirements
- R1: After synchronous reset every attribute word, every control output and bus_rdata are zero: function 0 (disabled/analog), no pull, unlocked.
- R2: A write to address p (p < NUM_PINS) loads bus_wdata[15:0] into pad p only. On the outputs, bits 1:0 appear on pad_pull (0 none, 2 down, 3 up), bit 2 on pad_slow, bit 4 on pad_filt, bit 5 on pad_odrain, bit 6 on pad_hidrive, bits 8 upward (MUX_W bits) on pad_func and bit 15 on pad_lock. Other pads keep their values.
- R3: Reserved bits 3, 7, bits 8+MUX_W to 14 and read bits 31:16 always read zero, whatever was written.
- R4: A write to address NUM_PINS (low fan-out) loads bus_wdata[15:0] into every pad k in 0..15 whose mask bit bus_wdata[16+k] is 1. Unmasked pads are unchanged.
- R5: A write to address NUM_PINS+1 (high fan-out) loads bus_wdata[15:0] into every pad 16+k whose mask bit bus_wdata[16+k] is 1.
- R6: A pad whose lock bit (bit 15) is set ignores single writes to its address. All of its bits 15:0 stay unchanged.
- R7: Fan-out writes skip locked pads and still update unlocked masked pads.
- R8: Reads of the two fan-out addresses, or of any address at or above NUM_PINS, return zero.
- R9: Read data is registered. It appears on the clock edge that accepts the read and holds until the next read.
- R10: A lock bit, once set, is cleared only by reset. Reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | BUS_AW | Word address |
| bus_wdata | input | 32 | Write data; mask in 31:16 for fan-out writes |
| bus_rdata | output | 32 | Registered read data |
| pad_pull | output | 2*NUM_PINS | Pull select, 2 bits per pad |
| pad_slow | output | NUM_PINS | Slow edge rate per pad |
| pad_filt | output | NUM_PINS | Passive filter enable per pad |
| pad_odrain | output | NUM_PINS | Open-drain enable per pad |
| pad_hidrive | output | NUM_PINS | High drive strength per pad |
| pad_func | output | MUX_W*NUM_PINS | Function selector per pad |
| pad_lock | output | NUM_PINS | Lock flag per pad |

## Verification
The bench goes after the mask-to-pad mapping of both fan-out addresses. A design that swapped halves or offset the mask would update the wrong pads, and the full per-pad readback after every fan-out would expose it. Locked pads are hit by single and fan-out writes, including all-ones masks. A design that let a fan-out bypass the lock, or let a write of zero clear the lock, would change a frozen word. Patterns with reserved bits set catch a design that stores them. A sweep over many data values on one pad checks each field's bit position against the output vectors, and reads of the fan-out and unmapped addresses catch decodes that alias onto pad words.

// File: rtl/pin_cfg_pkg.sv
package pin_cfg_pkg;
  localparam int unsigned ATTR_W   = 16;
  localparam int unsigned PULL_LSB = 0;
  localparam int unsigned SLOW_BIT = 2;
  localparam int unsigned FILT_BIT = 4;
  localparam int unsigned ODRN_BIT = 5;
  localparam int unsigned HDRV_BIT = 6;
  localparam int unsigned FUNC_LSB = 8;
  localparam int unsigned LOCK_BIT = 15;
  localparam int unsigned FANOUT_W = 16;

  // Bits that hold state; all others are reserved
  function automatic logic [ATTR_W-1:0] keep_mask(input int unsigned mux_w);
    logic [ATTR_W-1:0] m;
    m = '0;
    m[PULL_LSB +: 2] = 2'b11;
    m[SLOW_BIT] = 1'b1;
    m[FILT_BIT] = 1'b1;
    m[ODRN_BIT] = 1'b1;
    m[HDRV_BIT] = 1'b1;
    for (int i = 0; i < 4; i++) if (i < int'(mux_w)) m[FUNC_LSB+i] = 1'b1;
    m[LOCK_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pin_cfg_slot.sv
module pin_cfg_slot
  import pin_cfg_pkg::*;
#(
  parameter int unsigned MUX_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ATTR_W-1:0] load_val,
  output logic [ATTR_W-1:0] attr
);
  localparam logic [ATTR_W-1:0] KEEP = keep_mask(MUX_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      attr <= '0;
    end else if (load && !attr[LOCK_BIT]) begin
      attr <= load_val & KEEP;
    end
  end
endmodule

// File: rtl/pin_cfg_rdmux.sv
module pin_cfg_rdmux
  import pin_cfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned BUS_AW   = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [BUS_AW-1:0]                 rd_addr,
  input  logic [NUM_PINS-1:0][ATTR_W-1:0]   attrs,
  output logic [31:0]                       rd_data
);
  localparam int unsigned PIN_AW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr < BUS_AW'(NUM_PINS)) rd_data <= {16'h0000, attrs[rd_addr[PIN_AW-1:0]]};
      else                             rd_data <= '0;
    end
  end
endmodule

// File: rtl/pin_cfg_bank.sv
module pin_cfg_bank
  import pin_cfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned MUX_W    = 3,
  parameter int unsigned BUS_AW   = $clog2(NUM_PINS) + 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_valid,
  input  logic                      bus_write,
  input  logic [BUS_AW-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic [2*NUM_PINS-1:0]     pad_pull,
  output logic [NUM_PINS-1:0]       pad_slow,
  output logic [NUM_PINS-1:0]       pad_filt,
  output logic [NUM_PINS-1:0]       pad_odrain,
  output logic [NUM_PINS-1:0]       pad_hidrive,
  output logic [MUX_W*NUM_PINS-1:0] pad_func,
  output logic [NUM_PINS-1:0]       pad_lock
);
  localparam logic [BUS_AW-1:0] FAN_LO = BUS_AW'(NUM_PINS);
  localparam logic [BUS_AW-1:0] FAN_HI = BUS_AW'(NUM_PINS + 1);

  logic wr_req, rd_req, sel_lo, sel_hi;
  logic [NUM_PINS-1:0][ATTR_W-1:0] attrs;

  assign wr_req = bus_valid && bus_write;
  assign rd_req = bus_valid && !bus_write;
  assign sel_lo = wr_req && (bus_addr == FAN_LO);
  assign sel_hi = wr_req && (bus_addr == FAN_HI);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic hit_one, hit_fan;
    assign hit_one = wr_req && (bus_addr == BUS_AW'(p));
    if (p < FANOUT_W) begin : g_lo
      assign hit_fan = sel_lo && bus_wdata[FANOUT_W + p];
    end else begin : g_hi
      assign hit_fan = sel_hi && bus_wdata[p];
    end

    pin_cfg_slot #(.MUX_W(MUX_W)) i_slot (
      .clk      (clk),
      .rst      (rst),
      .load     (hit_one || hit_fan),
      .load_val (bus_wdata[ATTR_W-1:0]),
      .attr     (attrs[p])
    );

    assign pad_pull[2*p +: 2]        = attrs[p][PULL_LSB +: 2];
    assign pad_slow[p]               = attrs[p][SLOW_BIT];
    assign pad_filt[p]               = attrs[p][FILT_BIT];
    assign pad_odrain[p]             = attrs[p][ODRN_BIT];
    assign pad_hidrive[p]            = attrs[p][HDRV_BIT];
    assign pad_func[MUX_W*p +: MUX_W] = attrs[p][FUNC_LSB +: MUX_W];
    assign pad_lock[p]               = attrs[p][LOCK_BIT];
  end

  pin_cfg_rdmux #(.NUM_PINS(NUM_PINS), .BUS_AW(BUS_AW)) i_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_req),
    .rd_addr (bus_addr),
    .attrs   (attrs),
    .rd_data (bus_rdata)
  );
endmodule

// File: rtl/pin_cfg_bank_chk.sv
module pin_cfg_bank_chk #(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned MUX_W    = 3,
  parameter int unsigned BUS_AW   = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_valid,
  input logic                      bus_write,
  input logic [BUS_AW-1:0]         bus_addr,
  input logic [31:0]               bus_rdata,
  input logic [NUM_PINS-1:0]       pad_slow,
  input logic [MUX_W*NUM_PINS-1:0] pad_func,
  input logic [NUM_PINS-1:0]       pad_lock
);
  logic [MUX_W*NUM_PINS-1:0] lock_wide;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_w
    assign lock_wide[MUX_W*p +: MUX_W] = {MUX_W{pad_lock[p]}};
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (pad_lock == '0 && pad_func == '0 && bus_rdata == '0));

  // R3
  rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (rst) bus_rdata[31:16] == 16'h0000 && bus_rdata[3] == 1'b0 && bus_rdata[7] == 1'b0);

  // R6
  locked_func_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (((pad_func ^ $past(pad_func)) & $past(lock_wide)) == '0));

  // R6
  locked_slew_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (((pad_slow ^ $past(pad_slow)) & $past(pad_lock)) == '0));

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ((pad_lock & $past(pad_lock)) == $past(pad_lock)));

  // R10
  lock_only_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(bus_valid && bus_write)) |-> $stable(pad_lock));

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write && bus_addr >= BUS_AW'(NUM_PINS)) |=> bus_rdata == '0);

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(bus_valid && !bus_write)) |-> $stable(bus_rdata));
endmodule

bind pin_cfg_bank pin_cfg_bank_chk #(.NUM_PINS(NUM_PINS), .MUX_W(MUX_W), .BUS_AW(BUS_AW)) i_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_slow(pad_slow), .pad_func(pad_func), .pad_lock(pad_lock)
);

// File: tb/test_pin_cfg_bank.sv
`timescale 1ns/1ps
module test_pin_cfg_bank;
  localparam int NP = 32;
  localparam int MW = 3;
  localparam int AW = 6;
  localparam logic [15:0] KEEP = 16'h8777;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2*NP-1:0] pad_pull;
  logic [NP-1:0] pad_slow, pad_filt, pad_odrain, pad_hidrive, pad_lock;
  logic [MW*NP-1:0] pad_func;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] model [NP];

  always #2 clk = ~clk;

  pin_cfg_bank #(.NUM_PINS(NP), .MUX_W(MW), .BUS_AW(AW)) i_pin_cfg_bank (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_pull(pad_pull), .pad_slow(pad_slow),
    .pad_filt(pad_filt), .pad_odrain(pad_odrain), .pad_hidrive(pad_hidrive),
    .pad_func(pad_func), .pad_lock(pad_lock));

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      summary();
      $finish;
    end
  end

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  function automatic void m_one(input int p, input logic [15:0] d);
    if (!model[p][15]) model[p] = d & KEEP;
  endfunction

  function automatic void m_fan(input bit hi, input logic [31:0] w);
    for (int k = 0; k < 16; k++)
      if (w[16+k]) m_one(hi ? 16 + k : k, w[15:0]);
  endfunction

  task automatic check_pin(input string req, input int p);
    logic [31:0] r;
    logic [15:0] e;
    e = model[p];
    rd(AW'(p), r);
    cmp({req, " readback"}, r, {16'h0, e});
    cmp({req, " pad outputs"},
        {20'h0, pad_lock[p], pad_func[p*MW +: MW], pad_hidrive[p], pad_odrain[p], pad_filt[p],
         pad_slow[p], pad_pull[2*p +: 2]},
        {20'h0, e[15], e[8 +: MW], e[6], e[5], e[4], e[2], e[1:0]});
  endtask

  task automatic check_all(input string req);
    for (int p = 0; p < NP; p++) check_pin(req, p);
  endtask

  logic [31:0] r;
  logic [15:0] d;

  initial begin
    for (int p = 0; p < NP; p++) model[p] = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    cmp("R1 rdata after reset", bus_rdata, 32'h0);
    cmp("R1 lock vector", {{(64-NP){1'b0}}, pad_lock}, 64'h0);
    check_all("R1");

    // R2/R3: distinct single writes with reserved bits set, neighbour untouched
    for (int p = 0; p < NP; p++) begin
      d = (16'(p) * 16'h0b13) ^ 16'h7e8d;
      d[15] = 1'b0;
      wr(AW'(p), {16'hffff, d});
      m_one(p, d);
      check_pin("R2 target", p);
      check_pin("R2 neighbour", (p + 1) % NP);
    end
    check_all("R3 reserved bits");

    // R2: read-modify-write of the function field only
    rd(AW'(9), r);
    r[8 +: MW] = 3'd5;
    wr(AW'(9), r);
    m_one(9, r[15:0]);
    check_all("R2 rmw function");

    // R4/R5: fan-out writes
    wr(AW'(NP), {16'ha5c3, 16'h0245});
    m_fan(0, {16'ha5c3, 16'h0245});
    check_all("R4 fan low");
    wr(AW'(NP + 1), {16'h3c0f, 16'h7fff});
    m_fan(1, {16'h3c0f, 16'h7fff});
    check_all("R5 fan high");

    // R8: fan-out and unmapped addresses read zero
    rd(AW'(NP), r);      cmp("R8 fan low read", r, 32'h0);
    rd(AW'(NP + 1), r);  cmp("R8 fan high read", r, 32'h0);
    rd(AW'(50), r);      cmp("R8 unmapped read", r, 32'h0);

    // R9: read data holds across a write
    rd(AW'(4), r);
    wr(AW'(4), 32'h0000_0003);
    m_one(4, 16'h0003);
    cmp("R9 rdata held", bus_rdata, r);

    // R6/R7: lock pins 3 and 20, then attack them
    wr(AW'(3), 32'h0000_8512);  m_one(3, 16'h8512);
    wr(AW'(20), 32'h0000_8361); m_one(20, 16'h8361);
    wr(AW'(3), 32'h0000_0000);  m_one(3, 16'h0000);
    wr(AW'(20), 32'h0000_0077); m_one(20, 16'h0077);
    check_pin("R6 locked single", 3);
    check_pin("R6 locked single", 20);
    wr(AW'(NP), {16'hffff, 16'h0033});     m_fan(0, {16'hffff, 16'h0033});
    wr(AW'(NP + 1), {16'hffff, 16'h0144}); m_fan(1, {16'hffff, 16'h0144});
    check_all("R7 fan skips locked");

    // R2: bit-position sweep on pad 7
    for (int i = 0; i < 96; i++) begin
      d = 16'(i * 16'h02b7) & 16'h7fff;
      wr(AW'(7), {16'h0, d});
      m_one(7, d);
      check_pin("R2 sweep", 7);
    end

    // R10: lock survives repeated clears, reset clears it
    wr(AW'(3), 32'h0000_0000);
    cmp("R10 lock kept", {31'h0, pad_lock[3]}, 32'h1);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int p = 0; p < NP; p++) model[p] = '0;
    cmp("R10 lock cleared by reset", {{(64-NP){1'b0}}, pad_lock}, 64'h0);
    wr(AW'(3), 32'h0000_0101); m_one(3, 16'h0101);
    check_all("R10 after reset");

    done = 1;
    summary();
    $finish;
  end
endmodule